// File: doc/BRIEF.md
# ATM Inverse-Multiplexing Transmit Cell Scheduler

This block takes one stream of ATM cell descriptors and spreads it over a group of parallel low-rate links, one cell per slot, in strict round-robin order. Each link asks for a cell with its own slot request. Every link's slot stream is divided into fixed-length frames. The first slot of each frame carries a control cell. On the timing reference link, a pair of stuff control cells is sent once per stuff period. A slot that no user cell can take carries a filler cell.

Cells are represented by descriptors: a 2-bit type, a payload index, and for control and stuff cells the position of the cell within its frame, the number of links in service and the in-service map of the group. Links are taken out of or returned to service with a group mask. A change to the mask takes effect only at a frame boundary, so all links see the change at the same frame.

Top module: `ima_tx_sched`

## Requirements
- R1: Reset clears every frame and stuff counter, sets the round-robin pointer to link 0 and holds `tx_valid` and `in_ready` low. The first requested slot of every link after reset is a control cell, and the first user cell after reset goes to link 0.
- R2: User cells go to the in-service links in ascending link order and wrap around after the highest link. The pointer moves only when a user cell is sent, and at most one user cell is sent per cycle.
- R3: When `slot_req[i]` is high, `tx_valid[i]` is high in the next cycle and the cell fields for link i are updated. When `slot_req[i]` is low, `tx_valid[i]` is low in the next cycle and link i's counters do not advance.
- R4: Cell type encoding is 00 filler, 01 user, 10 control, 11 stuff. Slot 0 of every FRAME_LEN-slot frame of every link is a control cell, and its offset field holds 0.
- R5: On link TRL_LINK only, the slots numbered STUFF_PERIOD-2 and STUFF_PERIOD-1 of every STUFF_PERIOD slots (counted from reset) are stuff cells. Their offset fields hold their frame positions. A stuff cell takes priority over a control cell.
- R6: A requested slot that carries neither a control nor a stuff cell carries a filler cell when `in_valid` is low at that edge, or when the link is not the pointer link.
- R7: `in_ready` is high only in a cycle in which the pointer link requests a slot, that link is in service, and the slot is not a control or stuff slot. A cell is taken only when `in_valid` and `in_ready` are both high.
- R8: On control and stuff cells, the link-count field equals the number of ones in the map field. The map field is the group mask in force for that frame. Both fields are zero on other cell types.
- R9: `grp_mask` is sampled only at a frame boundary, which is a requested control slot of the timing reference link. At that boundary the pointer moves to the lowest-numbered in-service link at or after its current value, wrapping around.
- R10: A link outside the in-service mask never carries a user cell. It still sends control cells, stuff cells (if it is the reference link) and filler cells.
- R11: A user cell carries `in_desc` as sampled at the accepting edge. Filler, control and stuff cells carry a zero descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A user cell descriptor is offered |
| in_ready | output | 1 | The offered cell is taken at this edge |
| in_desc | input | DESC_W | User cell descriptor |
| grp_mask | input | N_LINKS | Requested in-service link mask |
| slot_req | input | N_LINKS | Per-link request for a cell for the next slot |
| tx_valid | output | N_LINKS | Per-link cell output valid |
| tx_type | output | 2*N_LINKS | Per-link cell type |
| tx_desc | output | DESC_W*N_LINKS | Per-link carried descriptor |
| tx_offset | output | 8*N_LINKS | Per-link frame position field of control and stuff cells |
| tx_links | output | 5*N_LINKS | Per-link in-service link count field |
| tx_map | output | N_LINKS*N_LINKS | Per-link in-service map field |

## Verification
`in_ready` is a combinational function of the current pointer, the registered mask, the frame position and `slot_req`. The bench therefore drives inputs at the falling edge and checks `in_ready` 2 ns later, in the same cycle. Every per-link cell field passes through exactly one register. The bench checks these fields at the falling edge after the accepting rising edge. A mask change is visible only in the cycle after the boundary slot's edge. To show that it is ignored until then, the bench changes the mask in mid-frame and tracks cell placement slot by slot through the boundary. A reference model in the bench steps the slot counter, the pointer and the mask once per requested slot, so stuff slots 2046 and 2047 and every frame start are checked at their exact cycle.

// File: rtl/ima_tx_pkg.sv
package ima_tx_pkg;
    typedef enum logic [1:0] {
        CELL_FILL  = 2'b00,
        CELL_USER  = 2'b01,
        CELL_CTRL  = 2'b10,
        CELL_STUFF = 2'b11
    } cell_t;

    localparam int LCNT_W = 5;
    localparam int OFS_W  = 8;
endpackage

// File: rtl/ima_tx_slot_ctr.sv
module ima_tx_slot_ctr #(
    parameter int FRAME_LEN    = 128,
    parameter int STUFF_PERIOD = 2048,
    parameter bit HAS_STUFF    = 1'b0,
    localparam int POS_W       = $clog2(FRAME_LEN),
    localparam int STF_W       = $clog2(STUFF_PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [POS_W-1:0] slot_pos,
    output logic             ctrl_slot,
    output logic             stuff_slot
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
    } frm_t;

    frm_t frm_d, frm_q;

    always_comb begin
        frm_d = frm_q;
        if (adv) begin
            frm_d.pos = (frm_q.pos == POS_W'(FRAME_LEN - 1)) ? '0 : frm_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign slot_pos  = frm_q.pos;
    assign ctrl_slot = (frm_q.pos == '0);

    generate
        if (HAS_STUFF) begin : g_stuff
            logic [STF_W-1:0] stf_d, stf_q;

            always_comb begin
                stf_d = stf_q;
                if (adv) begin
                    stf_d = (stf_q == STF_W'(STUFF_PERIOD - 1)) ? '0 : stf_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) stf_q <= '0;
                else        stf_q <= stf_d;
            end

            assign stuff_slot = (stf_q >= STF_W'(STUFF_PERIOD - 2));
        end else begin : g_nostuff
            assign stuff_slot = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ima_tx_rr_pick.sv
module ima_tx_rr_pick #(
    parameter int N_LINKS = 4,
    localparam int IDX_W  = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input  logic [N_LINKS-1:0] mask,
    input  logic [IDX_W-1:0]   start,
    output logic [IDX_W-1:0]   idx,
    output logic               found
);
    always_comb begin
        found = 1'b0;
        idx   = start;
        for (int d = N_LINKS - 1; d >= 0; d--) begin
            int j;
            j = (int'(start) + d) % N_LINKS;
            if (mask[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/ima_tx_sched.sv
module ima_tx_sched
    import ima_tx_pkg::*;
#(
    parameter int N_LINKS      = 4,
    parameter int FRAME_LEN    = 128,
    parameter int STUFF_PERIOD = 2048,
    parameter int TRL_LINK     = 0,
    parameter int DESC_W       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [DESC_W-1:0]             in_desc,
    input  logic [N_LINKS-1:0]            grp_mask,
    input  logic [N_LINKS-1:0]            slot_req,
    output logic [N_LINKS-1:0]            tx_valid,
    output logic [2*N_LINKS-1:0]          tx_type,
    output logic [DESC_W*N_LINKS-1:0]     tx_desc,
    output logic [8*N_LINKS-1:0]          tx_offset,
    output logic [5*N_LINKS-1:0]          tx_links,
    output logic [N_LINKS*N_LINKS-1:0]    tx_map
);
    localparam int IDX_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;
    localparam int POS_W = $clog2(FRAME_LEN);

    typedef struct packed {
        logic [IDX_W-1:0]              ptr;
        logic [N_LINKS-1:0]            act;
        logic [N_LINKS-1:0]            vld;
        logic [2*N_LINKS-1:0]          typ;
        logic [DESC_W*N_LINKS-1:0]     desc;
        logic [OFS_W*N_LINKS-1:0]      ofs;
        logic [LCNT_W*N_LINKS-1:0]     lcnt;
        logic [N_LINKS*N_LINKS-1:0]    map;
    } st_t;

    st_t st_d, st_q;

    logic [POS_W-1:0]   pos_v [N_LINKS];
    logic [N_LINKS-1:0] ctrl_v;
    logic [N_LINKS-1:0] stuff_v;

    generate
        for (genvar g = 0; g < N_LINKS; g++) begin : g_lane
            ima_tx_slot_ctr #(
                .FRAME_LEN    (FRAME_LEN),
                .STUFF_PERIOD (STUFF_PERIOD),
                .HAS_STUFF    (g == TRL_LINK)
            ) u_ctr (
                .clk        (clk),
                .rst_n      (rst_n),
                .adv        (slot_req[g]),
                .slot_pos   (pos_v[g]),
                .ctrl_slot  (ctrl_v[g]),
                .stuff_slot (stuff_v[g])
            );
        end
    endgenerate

    logic               boundary;
    logic [N_LINKS-1:0] map_now;
    logic [LCNT_W-1:0]  lcnt_now;
    logic               user_ok;
    logic               pop;
    logic [IDX_W-1:0]   adv_start;
    logic [IDX_W-1:0]   adv_idx;
    logic               adv_found;
    logic [IDX_W-1:0]   ptr_base;
    logic [IDX_W-1:0]   bnd_idx;
    logic               bnd_found;

    assign boundary  = slot_req[TRL_LINK] && ctrl_v[TRL_LINK];
    assign map_now   = boundary ? grp_mask : st_q.act;
    assign user_ok   = slot_req[st_q.ptr] && st_q.act[st_q.ptr]
                       && !ctrl_v[st_q.ptr] && !stuff_v[st_q.ptr];
    assign pop       = in_valid && user_ok;
    assign in_ready  = user_ok;
    assign adv_start = (st_q.ptr == IDX_W'(N_LINKS - 1)) ? '0 : st_q.ptr + 1'b1;
    assign ptr_base  = (pop && adv_found) ? adv_idx : st_q.ptr;

    always_comb begin
        lcnt_now = '0;
        for (int i = 0; i < N_LINKS; i++) begin
            lcnt_now = lcnt_now + LCNT_W'(map_now[i]);
        end
    end

    ima_tx_rr_pick #(.N_LINKS(N_LINKS)) u_next (
        .mask  (st_q.act),
        .start (adv_start),
        .idx   (adv_idx),
        .found (adv_found)
    );

    ima_tx_rr_pick #(.N_LINKS(N_LINKS)) u_realign (
        .mask  (grp_mask),
        .start (ptr_base),
        .idx   (bnd_idx),
        .found (bnd_found)
    );

    always_comb begin
        st_d     = '0;
        st_d.act = boundary ? grp_mask : st_q.act;
        st_d.ptr = (boundary && bnd_found) ? bnd_idx : ptr_base;
        for (int i = 0; i < N_LINKS; i++) begin
            st_d.vld[i] = slot_req[i];
            if (slot_req[i]) begin
                if (stuff_v[i] || ctrl_v[i]) begin
                    st_d.typ[2*i +: 2]           = stuff_v[i] ? CELL_STUFF : CELL_CTRL;
                    st_d.ofs[OFS_W*i +: OFS_W]   = OFS_W'(pos_v[i]);
                    st_d.lcnt[LCNT_W*i +: LCNT_W] = lcnt_now;
                    st_d.map[N_LINKS*i +: N_LINKS] = map_now;
                end else if (pop && (st_q.ptr == IDX_W'(i))) begin
                    st_d.typ[2*i +: 2]            = CELL_USER;
                    st_d.desc[DESC_W*i +: DESC_W] = in_desc;
                end else begin
                    st_d.typ[2*i +: 2] = CELL_FILL;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.act <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid  = st_q.vld;
    assign tx_type   = st_q.typ;
    assign tx_desc   = st_q.desc;
    assign tx_offset = st_q.ofs;
    assign tx_links  = st_q.lcnt;
    assign tx_map    = st_q.map;
endmodule

// File: rtl/ima_tx_sched_chk.sv
module ima_tx_sched_chk #(
    parameter int N_LINKS  = 4,
    parameter int TRL_LINK = 0,
    parameter int DESC_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [N_LINKS-1:0]         slot_req,
    input logic [N_LINKS-1:0]         tx_valid,
    input logic [2*N_LINKS-1:0]       tx_type,
    input logic [8*N_LINKS-1:0]       tx_offset,
    input logic [5*N_LINKS-1:0]       tx_links,
    input logic [N_LINKS*N_LINKS-1:0] tx_map
);
    localparam logic [N_LINKS-1:0] TRL_BIT = N_LINKS'(1) << TRL_LINK;

    logic [N_LINKS-1:0] user_l;
    logic [N_LINKS-1:0] stuff_l;

    generate
        for (genvar g = 0; g < N_LINKS; g++) begin : g_l
            assign user_l[g]  = tx_valid[g] && (tx_type[2*g +: 2] == 2'b01);
            assign stuff_l[g] = tx_valid[g] && (tx_type[2*g +: 2] == 2'b11);

            // R4: control cells sit at frame position 0
            p_ctrl_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[g] && tx_type[2*g +: 2] == 2'b10) |-> (tx_offset[8*g +: 8] == 8'd0));

            // R8: link count agrees with the map carried beside it
            p_count_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[g] && tx_type[2*g+1]) |->
                (tx_links[5*g +: 5] == 5'($countones(tx_map[N_LINKS*g +: N_LINKS]))));
        end
    endgenerate

    p_valid_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (tx_valid == $past(slot_req)));

    p_single_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(user_l));

    p_pop_gives_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ($countones(user_l) == 1));

    p_no_pop_no_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> (user_l == '0));

    p_ready_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (slot_req != '0));

    p_stuff_on_trl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stuff_l & ~TRL_BIT) == '0));
endmodule

bind ima_tx_sched ima_tx_sched_chk #(
    .N_LINKS  (N_LINKS),
    .TRL_LINK (TRL_LINK),
    .DESC_W   (DESC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .slot_req  (slot_req),
    .tx_valid  (tx_valid),
    .tx_type   (tx_type),
    .tx_offset (tx_offset),
    .tx_links  (tx_links),
    .tx_map    (tx_map)
);

// File: tb/ima_tx_sched_test.sv
module ima_tx_sched_test;
    localparam int N   = 4;
    localparam int M   = 128;
    localparam int P   = 2048;
    localparam int TRL = 0;
    localparam int DW  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [DW-1:0]     in_desc;
    logic [N-1:0]      grp_mask;
    logic [N-1:0]      slot_req;
    logic              in_ready;
    logic [N-1:0]      tx_valid;
    logic [2*N-1:0]    tx_type;
    logic [DW*N-1:0]   tx_desc;
    logic [8*N-1:0]    tx_offset;
    logic [5*N-1:0]    tx_links;
    logic [N*N-1:0]    tx_map;

    int n_chk  = 0;
    int n_fail = 0;

    int          sc;
    int          m_ptr;
    logic [N-1:0] m_act;

    always #4 clk = ~clk;

    ima_tx_sched #(
        .N_LINKS(N), .FRAME_LEN(M), .STUFF_PERIOD(P), .TRL_LINK(TRL), .DESC_W(DW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .grp_mask(grp_mask), .slot_req(slot_req),
        .tx_valid(tx_valid), .tx_type(tx_type), .tx_desc(tx_desc),
        .tx_offset(tx_offset), .tx_links(tx_links), .tx_map(tx_map)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (slot %0d)", req, what, act, exp, sc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One slot: drive at falling edge, check ready, then check registered lane fields.
    task automatic step(input logic [N-1:0] req, input logic v, input logic [DW-1:0] d,
                        input logic [N-1:0] mask, input string tag);
        bit full, bnd, ctl, stp, okp, pop;
        int idx, lc, et;
        logic [N-1:0] mapn;
        slot_req = req; in_valid = v; in_desc = d; grp_mask = mask;
        full = (req == '1);
        idx  = sc % M;
        ctl  = full && (idx == 0);
        bnd  = ctl;
        mapn = bnd ? mask : m_act;
        lc   = $countones(mapn);
        stp  = full && (m_ptr == TRL) && ((sc % P) >= P - 2);
        okp  = full && m_act[m_ptr] && !ctl && !stp;
        pop  = v && okp;
        #2;
        chk((tag == "R3") ? "R3" : "R7", "in_ready", int'(in_ready), int'(okp));
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            chk("R3", $sformatf("tx_valid[%0d]", i), int'(tx_valid[i]), int'(req[i]));
            if (full) begin
                if ((i == TRL) && ((sc % P) >= P - 2)) et = 3;
                else if (ctl)                          et = 2;
                else if (pop && (i == m_ptr))          et = 1;
                else                                   et = 0;
                chk((et == 3) ? "R5" : (et == 2) ? "R4" : tag,
                    $sformatf("tx_type[%0d]", i), int'(tx_type[2*i +: 2]), et);
                chk("R11", $sformatf("tx_desc[%0d]", i), int'(tx_desc[DW*i +: DW]),
                    (et == 1) ? int'(d) : 0);
                if (et >= 2) begin
                    chk((et == 3) ? "R5" : "R4", $sformatf("tx_offset[%0d]", i),
                        int'(tx_offset[8*i +: 8]), idx);
                    chk("R8", $sformatf("tx_links[%0d]", i), int'(tx_links[5*i +: 5]), lc);
                    chk((tag == "R9") ? "R9" : "R8", $sformatf("tx_map[%0d]", i),
                        int'(tx_map[N*i +: N]), int'(mapn));
                end
            end
        end
        if (full) begin
            if (pop) begin
                for (int k = 1; k <= N; k++) begin
                    if (m_act[(m_ptr + k) % N]) begin
                        m_ptr = (m_ptr + k) % N;
                        break;
                    end
                end
            end
            if (bnd) begin
                m_act = mask;
                for (int k = 0; k < N; k++) begin
                    if (mask[(m_ptr + k) % N]) begin
                        m_ptr = (m_ptr + k) % N;
                        break;
                    end
                end
            end
            sc++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_desc = '0; grp_mask = '1; slot_req = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "tx_valid in reset", int'(tx_valid), 0);
        chk("R1", "in_ready in reset", int'(in_ready), 0);
        rst_n = 1'b1;
        sc = 0; m_ptr = 0; m_act = '1;
        step('1, 1'b1, 8'hA5, '1, "R1");   // first slot: control everywhere
        step('1, 1'b1, 8'h11, '1, "R1");   // first user cell lands on link 0
        chk("R1", "user on link 0 after reset", int'(tx_type[1:0]), 1);
    endtask

    task automatic t_round_robin();
        for (int k = 0; k < 9; k++) step('1, 1'b1, DW'(8'h20 + k), '1, "R2");
    endtask

    task automatic t_gaps();
        for (int k = 0; k < 6; k++) step('1, k[0], DW'(8'h40 + k), '1, "R6");
    endtask

    task automatic t_idle();
        for (int k = 0; k < 3; k++) step('0, 1'b1, 8'h55, '1, "R3");
        step('1, 1'b1, 8'h56, '1, "R3");
    endtask

    task automatic t_mask();
        // mask changed mid-frame: old group stays in force until boundary
        for (int k = 0; k < 4; k++) step('1, 1'b1, DW'(8'h60 + k), 4'b1010, "R9");
        while ((sc % M) != 0) step('1, 1'b1, DW'(sc), 4'b1010, "R9");
        step('1, 1'b1, 8'h70, 4'b1010, "R9");
        for (int k = 0; k < 8; k++) begin
            step('1, 1'b1, DW'(8'h71 + k), 4'b1010, "R10");
            chk("R10", "no user on link 0", int'(tx_type[1:0] == 2'b01), 0);
            chk("R10", "no user on link 2", int'(tx_type[5:4] == 2'b01), 0);
        end
        while ((sc % M) != 0) step('1, sc[0], DW'(sc), 4'b1111, "R9");
        for (int k = 0; k < 6; k++) step('1, 1'b1, DW'(8'h90 + k), 4'b1111, "R9");
    endtask

    task automatic t_stuff();
        while (sc < P + 3) step('1, (sc % 3) != 0, DW'(sc), '1, "R5");
    endtask

    initial begin
        t_reset();
        t_round_robin();
        t_gaps();
        t_idle();
        t_mask();
        t_stuff();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule